// File: doc/BRIEF.md
# Four-State Snooping Coherence Controller

This block keeps the coherence state of every line of a small direct-mapped write-back cache that sits on a shared snooping bus. Each line is Invalid, Shared, Exclusive-clean or Exclusive-dirty. Local operations from the processor side are reads, writes, evictions and fills. Snooped bus commands are read-miss, write-miss and invalidate. Both kinds move lines between states. The block tells the bus interface which command to issue and whether this cache must supply a block to another requester.

Tag matching is done outside and arrives as a hit flag for each side. The data array and the replacement choice are also outside. On a fill, the bus interface reports two things: whether another cache supplied the block, and whether that supplier held it dirty. From these the line is loaded as Shared, Exclusive-clean or Exclusive-dirty. A dirty line moves to the requester on a read miss, and the old owner drops its copy.

All decisions are combinational from the stored state and the current inputs. The state array updates on the next rising clock edge. `lineState` always shows the state the local line will hold after that edge. When the local operation is idle, this is the line's current state.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. The state codes are Invalid=0, Shared=1, Exclusive-clean=2, Exclusive-dirty=3. `lineState` gives the next state of the line at `cpuIndex`; with `cpuOp`=idle (0) that is its current state.
- R2: Local op codes are idle=0, read=1, write=2, evict=3, fill=4. Bus command codes are none=0, read-miss=1, write-miss=2, invalidate=3, write-back=4. A read hit (`cpuHit`=1 on a valid line) issues none and leaves the state unchanged. A read miss (`cpuHit`=0, or the line is Invalid) issues read-miss and leaves the state unchanged.
- R3: A fill with `fillWrite`=0 loads Exclusive-clean when `fillFromCache`=0, Shared when `fillFromCache`=1 and `fillWasDirty`=0, and Exclusive-dirty when both flags are 1. A fill issues no bus command.
- R4: A write hit on an Exclusive-clean or Exclusive-dirty line makes it Exclusive-dirty and issues no bus command.
- R5: A write hit on a Shared line issues invalidate and makes the line Exclusive-dirty.
- R6: A write miss issues write-miss and leaves the state unchanged. A later fill with `fillWrite`=1 loads Exclusive-dirty.
- R7: A snooped read-miss that hits a valid line raises `supplyReq`. `supplyDirty` is 1 only when the line was Exclusive-dirty. Exclusive-dirty goes to Invalid, Exclusive-clean goes to Shared, and Shared stays Shared.
- R8: A snooped write-miss that hits a valid line raises `supplyReq` and makes the line Invalid. A snooped invalidate makes it Invalid without supplying. A snoop with `snpHit`=0, to an Invalid line, or with any other command code changes nothing and supplies nothing.
- R9: Evicting an Exclusive-dirty line issues write-back. Evicting a line in any other state is silent. In both cases the line becomes Invalid.
- R10: When a snoop and a local operation address the same line in one cycle, the snoop takes effect first and the local operation acts on the post-snoop state. On different lines, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuOp | input | 3 | Local operation code |
| cpuIndex | input | IDX_W | Line addressed by the local operation |
| cpuHit | input | 1 | External tag match for the local line |
| fillWrite | input | 1 | Fill answers a write miss |
| fillFromCache | input | 1 | Fill data came from another cache |
| fillWasDirty | input | 1 | Supplying cache held the block dirty |
| snpCmd | input | 3 | Snooped bus command code |
| snpIndex | input | IDX_W | Line addressed by the snoop |
| snpHit | input | 1 | External tag match for the snooped line |
| busCmd | output | 3 | Bus command to issue for the local operation |
| supplyReq | output | 1 | This cache must drive the snooped block |
| supplyDirty | output | 1 | Supplied block was held dirty |
| lineState | output | 2 | Next state of the local line |

## Verification
A local operation and a snoop can land in the same cycle. When they address the same line, their order decides both the bus command and the final state. The bench provokes this in three ways. A write hit on a Shared line meets a snooped invalidate, and must turn into a write-miss that leaves the line Invalid. A read hit on an Exclusive-clean line meets a snooped read-miss, and must stay silent while the line is demoted to Shared and supplied. An eviction of a dirty line runs beside a snoop on a different line, and both effects must appear. Each case is judged from the outputs in that cycle and from an idle read of both lines afterwards.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_EXC = 2'd2,
    ST_DRT = 2'd3
  } lineSt_e;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_EVICT = 3'd3,
    OP_FILL  = 3'd4
  } cpuOp_e;

  typedef enum logic [2:0] {
    BUS_NONE  = 3'd0,
    BUS_RDMS  = 3'd1,
    BUS_WRMS  = 3'd2,
    BUS_INVAL = 3'd3,
    BUS_WB    = 3'd4
  } busCmd_e;

  typedef struct packed {
    logic    wrSnp;
    lineSt_e snpNext;
    logic    wrLoc;
    lineSt_e locNext;
  } ctlStrobe_t;
endpackage

// File: rtl/coh_state_array.sv
module coh_state_array
  import coh_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       ctl,
  input  logic [IDX_W-1:0] locIdx,
  input  logic [IDX_W-1:0] snpIdx,
  output lineSt_e          locCur,
  output lineSt_e          snpCur
);
  localparam int DEPTH = 1 << IDX_W;

  lineSt_e stArr [DEPTH];

  assign locCur = stArr[locIdx];
  assign snpCur = stArr[snpIdx];

  // Snoop write first, local write second: on a shared index the local result wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) stArr[i] <= ST_INV;
    end else begin
      if (ctl.wrSnp) stArr[snpIdx] <= ctl.snpNext;
      if (ctl.wrLoc) stArr[locIdx] <= ctl.locNext;
    end
  end
endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  cpuOp_e           cpuOp,
  input  logic [IDX_W-1:0] cpuIndex,
  input  logic             cpuHit,
  input  logic             fillWrite,
  input  logic             fillFromCache,
  input  logic             fillWasDirty,
  input  logic [2:0]       snpCmd,
  input  logic [IDX_W-1:0] snpIndex,
  input  logic             snpHit,
  input  lineSt_e          locCur,
  input  lineSt_e          snpCur,
  output ctlStrobe_t       ctl,
  output busCmd_e          busCmd,
  output logic             supplyReq,
  output logic             supplyDirty,
  output lineSt_e          lineState
);
  logic    snpKnown;
  logic    snpEff;
  lineSt_e snpNext;
  lineSt_e locBase;
  logic    locHit;
  lineSt_e locNext;

  // Snoop side
  always_comb begin
    snpKnown = (snpCmd == BUS_RDMS) || (snpCmd == BUS_WRMS) || (snpCmd == BUS_INVAL);
    snpEff   = snpKnown && snpHit && (snpCur != ST_INV);
    snpNext  = snpCur;
    if (snpEff) begin
      if (snpCmd == BUS_RDMS) begin
        if (snpCur == ST_DRT)      snpNext = ST_INV;
        else if (snpCur == ST_EXC) snpNext = ST_SHR;
      end else begin
        snpNext = ST_INV;
      end
    end
    supplyReq   = snpEff && (snpCmd != BUS_INVAL);
    supplyDirty = supplyReq && (snpCur == ST_DRT);
  end

  // Local side acts on the post-snoop state of its line
  always_comb begin
    locBase = (snpEff && (snpIndex == cpuIndex)) ? snpNext : locCur;
    locHit  = cpuHit && (locBase != ST_INV);
    locNext = locBase;
    busCmd  = BUS_NONE;
    unique case (cpuOp)
      OP_READ: if (!locHit) busCmd = BUS_RDMS;
      OP_WRITE: begin
        if (locHit) begin
          if (locBase == ST_SHR) busCmd = BUS_INVAL;
          locNext = ST_DRT;
        end else begin
          busCmd = BUS_WRMS;
        end
      end
      OP_EVICT: begin
        if (locBase == ST_DRT) busCmd = BUS_WB;
        locNext = ST_INV;
      end
      OP_FILL: begin
        if (fillWrite || (fillFromCache && fillWasDirty)) locNext = ST_DRT;
        else if (fillFromCache)                           locNext = ST_SHR;
        else                                              locNext = ST_EXC;
      end
      default: ;
    endcase
  end

  always_comb begin
    ctl.wrSnp   = snpEff;
    ctl.snpNext = snpNext;
    ctl.wrLoc   = (cpuOp != OP_IDLE);
    ctl.locNext = locNext;
    lineState   = locNext;
  end

  AST_RDHIT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOp == OP_READ && locHit) |-> (busCmd == BUS_NONE && lineState == locBase)); // R2

  AST_EXCL_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOp == OP_WRITE && cpuHit && (locBase == ST_EXC || locBase == ST_DRT))
      |-> (busCmd == BUS_NONE && lineState == ST_DRT)); // R4

  AST_FILL_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (cpuOp == OP_FILL) |-> (lineState != ST_INV && busCmd == BUS_NONE)); // R3

  AST_SUPPLY_FROM_VALID: assert property (@(posedge clk) disable iff (!rstN)
    supplyReq |-> (snpCur != ST_INV && snpHit && (snpCmd == BUS_RDMS || snpCmd == BUS_WRMS))); // R7

  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    (busCmd == BUS_WB) |-> (cpuOp == OP_EVICT && locCur == ST_DRT)); // R9
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cpuOp,
  input  logic [IDX_W-1:0] cpuIndex,
  input  logic             cpuHit,
  input  logic             fillWrite,
  input  logic             fillFromCache,
  input  logic             fillWasDirty,
  input  logic [2:0]       snpCmd,
  input  logic [IDX_W-1:0] snpIndex,
  input  logic             snpHit,
  output logic [2:0]       busCmd,
  output logic             supplyReq,
  output logic             supplyDirty,
  output logic [1:0]       lineState
);
  ctlStrobe_t ctl;
  lineSt_e    locCur;
  lineSt_e    snpCur;
  busCmd_e    busCmdE;
  lineSt_e    lineStE;
  cpuOp_e     opE;

  always_comb begin
    opE = OP_IDLE;
    if (cpuOp <= 3'd4) opE = cpuOp_e'(cpuOp);
  end

  coh_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuOp(opE), .cpuIndex(cpuIndex), .cpuHit(cpuHit),
    .fillWrite(fillWrite), .fillFromCache(fillFromCache), .fillWasDirty(fillWasDirty),
    .snpCmd(snpCmd), .snpIndex(snpIndex), .snpHit(snpHit),
    .locCur(locCur), .snpCur(snpCur), .ctl(ctl), .busCmd(busCmdE),
    .supplyReq(supplyReq), .supplyDirty(supplyDirty), .lineState(lineStE)
  );

  coh_state_array #(.IDX_W(IDX_W)) u_array (
    .clk(clk), .rstN(rstN), .ctl(ctl), .locIdx(cpuIndex), .snpIdx(snpIndex),
    .locCur(locCur), .snpCur(snpCur)
  );

  assign busCmd    = busCmdE;
  assign lineState = lineStE;
endmodule

// File: tb/sim_coh_line_ctrl.sv
module sim_coh_line_ctrl;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [2:0]       cpuOp = 3'd0;
  logic [IDX_W-1:0] cpuIndex = '0;
  logic             cpuHit = 1'b0;
  logic             fillWrite = 1'b0;
  logic             fillFromCache = 1'b0;
  logic             fillWasDirty = 1'b0;
  logic [2:0]       snpCmd = 3'd0;
  logic [IDX_W-1:0] snpIndex = '0;
  logic             snpHit = 1'b0;
  logic [2:0]       busCmd;
  logic             supplyReq;
  logic             supplyDirty;
  logic [1:0]       lineState;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  coh_line_ctrl #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rstN(rstN), .cpuOp(cpuOp), .cpuIndex(cpuIndex), .cpuHit(cpuHit),
    .fillWrite(fillWrite), .fillFromCache(fillFromCache), .fillWasDirty(fillWasDirty),
    .snpCmd(snpCmd), .snpIndex(snpIndex), .snpHit(snpHit),
    .busCmd(busCmd), .supplyReq(supplyReq), .supplyDirty(supplyDirty), .lineState(lineState)
  );

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Drive one cycle's inputs at a falling edge and let them settle.
  task automatic setOp(int op, int idx, bit hit, bit fw, bit fc, bit fd,
                       int scmd, int sidx, bit shit);
    cpuOp = 3'(op); cpuIndex = IDX_W'(idx); cpuHit = hit;
    fillWrite = fw; fillFromCache = fc; fillWasDirty = fd;
    snpCmd = 3'(scmd); snpIndex = IDX_W'(sidx); snpHit = shit;
    #2;
  endtask

  task automatic advance();
    @(negedge clk);
    setOp(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic peek(int idx, int exp, string tag);
    setOp(0, idx, 0, 0, 0, 0, 0, 0, 0);
    chk(tag, lineState, exp);
    advance();
  endtask

  task automatic doFill(int idx, bit fw, bit fc, bit fd);
    setOp(4, idx, 0, fw, fc, fd, 0, 0, 0);
    advance();
  endtask

  task automatic t_reset();
    for (int i = 0; i < (1 << IDX_W); i += 5) peek(i, 0, "R1 reset Invalid");
    chk("R1 idle busCmd none", busCmd, 0);
  endtask

  task automatic t_read_and_fill();
    setOp(1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2 read miss busCmd", busCmd, 1);
    chk("R2 read miss state kept", lineState, 0);
    advance();
    setOp(1, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 hit on Invalid is miss", busCmd, 1);
    advance();
    doFill(1, 0, 0, 0);
    peek(1, 2, "R3 fill from memory Exclusive");
    setOp(1, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R2 read hit silent", busCmd, 0);
    chk("R2 read hit state kept", lineState, 2);
    advance();
    doFill(2, 0, 1, 0);
    peek(2, 1, "R3 fill from cache Shared");
    doFill(3, 0, 1, 1);
    peek(3, 3, "R3 fill from dirty cache Dirty");
  endtask

  task automatic t_writes();
    setOp(2, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R4 write hit Exclusive silent", busCmd, 0);
    chk("R4 write hit Exclusive to Dirty", lineState, 3);
    advance();
    setOp(2, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R4 write hit Dirty silent", busCmd, 0);
    advance();
    peek(1, 3, "R4 line Dirty");
    setOp(2, 2, 1, 0, 0, 0, 0, 0, 0);
    chk("R5 write hit Shared invalidate", busCmd, 3);
    chk("R5 write hit Shared to Dirty", lineState, 3);
    advance();
    peek(2, 3, "R5 line Dirty");
    setOp(2, 4, 0, 0, 0, 0, 0, 0, 0);
    chk("R6 write miss busCmd", busCmd, 2);
    chk("R6 write miss state kept", lineState, 0);
    advance();
    doFill(4, 1, 1, 0);
    peek(4, 3, "R6 write fill Dirty");
  endtask

  task automatic t_snoops();
    setOp(0, 1, 0, 0, 0, 0, 1, 1, 1);
    chk("R7 snoop rd Dirty supply", supplyReq, 1);
    chk("R7 snoop rd Dirty supplyDirty", supplyDirty, 1);
    chk("R7 snoop rd Dirty to Invalid", lineState, 0);
    advance();
    peek(1, 0, "R7 migrated line Invalid");
    doFill(5, 0, 0, 0);
    setOp(0, 5, 0, 0, 0, 0, 1, 5, 1);
    chk("R7 snoop rd Exclusive supply", supplyReq, 1);
    chk("R7 snoop rd Exclusive clean", supplyDirty, 0);
    chk("R7 snoop rd Exclusive to Shared", lineState, 1);
    advance();
    setOp(0, 5, 0, 0, 0, 0, 1, 5, 1);
    chk("R7 snoop rd Shared supply", supplyReq, 1);
    chk("R7 snoop rd Shared kept", lineState, 1);
    advance();
    setOp(0, 5, 0, 0, 0, 0, 2, 5, 0);
    chk("R8 snoop tag miss no supply", supplyReq, 0);
    advance();
    setOp(0, 5, 0, 0, 0, 0, 4, 5, 1);
    chk("R8 snoop other code no supply", supplyReq, 0);
    advance();
    peek(5, 1, "R8 snoop miss no effect");
    setOp(0, 5, 0, 0, 0, 0, 3, 5, 1);
    chk("R8 snoop invalidate no supply", supplyReq, 0);
    chk("R8 snoop invalidate to Invalid", lineState, 0);
    advance();
    peek(5, 0, "R8 invalidated line");
    doFill(6, 0, 0, 0);
    setOp(0, 6, 0, 0, 0, 0, 2, 6, 1);
    chk("R8 snoop wr supply", supplyReq, 1);
    chk("R8 snoop wr clean", supplyDirty, 0);
    advance();
    peek(6, 0, "R8 snoop wr to Invalid");
  endtask

  task automatic t_evict();
    setOp(3, 2, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 evict Dirty write-back", busCmd, 4);
    chk("R9 evict Dirty to Invalid", lineState, 0);
    advance();
    peek(2, 0, "R9 evicted line");
    doFill(7, 0, 1, 0);
    setOp(3, 7, 0, 0, 0, 0, 0, 0, 0);
    chk("R9 evict Shared silent", busCmd, 0);
    advance();
    peek(7, 0, "R9 evicted Shared line");
  endtask

  task automatic t_collide();
    doFill(8, 0, 1, 0);
    setOp(2, 8, 1, 0, 0, 0, 3, 8, 1);
    chk("R10 write vs invalidate becomes write-miss", busCmd, 2);
    chk("R10 write vs invalidate state", lineState, 0);
    advance();
    peek(8, 0, "R10 line Invalid after collision");
    doFill(9, 0, 1, 1);
    doFill(10, 0, 0, 0);
    setOp(3, 9, 0, 0, 0, 0, 1, 10, 1);
    chk("R10 evict beside snoop write-back", busCmd, 4);
    chk("R10 evict beside snoop supply", supplyReq, 1);
    chk("R10 evict beside snoop clean", supplyDirty, 0);
    advance();
    peek(9, 0, "R10 evicted line");
    peek(10, 1, "R10 snooped line Shared");
    doFill(11, 0, 0, 0);
    setOp(1, 11, 1, 0, 0, 0, 1, 11, 1);
    chk("R10 read vs snoop rd silent", busCmd, 0);
    chk("R10 read vs snoop rd Shared", lineState, 1);
    chk("R10 read vs snoop rd supply", supplyReq, 1);
    advance();
    peek(11, 1, "R10 line Shared after collision");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_and_fill();
    t_writes();
    t_snoops();
    t_evict();
    t_collide();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule